// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

A synchronous true dual-port memory of 2^ADDR_W words of DATA_W bits. It is 1024 x 8 by default and has two fully independent ports, left and right. Each port makes one request per clock. The request is built from an enable, a read/not-write select, an output enable, an address and write data. A read returns its word one clock later on a data bus, qualified by a valid flag. There is no back-pressure: the ports have no ready signal, so every accepted request completes, and the valid flag is a single-cycle pulse that the consumer must take in the cycle it appears.

The two highest words also serve as mailboxes between the ports. When the left port writes the top word, an interrupt is raised toward the right port. When the right port writes the word just below it, an interrupt is raised toward the left port. The receiving port drops its interrupt by reading that same word. Both mailbox words stay ordinary storage, so the message byte can be read back. A separate contention arbiter can assert a per-port write-inhibit input, which suppresses that port's writes and the mailbox effects those writes would have had.

Top module: `mbox_dpram`

## Requirements
- R1: After reset, both valid flags, both read-data buses and both interrupt outputs are 0.
- R2: A port with en=1, rnw=0 and inhibit=0 stores its write data at its address at the clock edge.
- R3: A port with en=1, rnw=1 and oe=1 presents the addressed word on rdata in the following cycle with rvalid=1 for that one cycle. In every cycle without such a result, rvalid=0 and rdata=0.
- R4: With en=0 a port performs neither a read nor a write, whatever its other inputs are.
- R5: A read with oe=0 gives no valid data and does not clear any interrupt.
- R6: A left-port write to the top address (all ones) sets r_irq in the next cycle. A right-port read (oe=1) of the top address clears it in the next cycle. A left-port read of that address leaves it unchanged.
- R7: A right-port write to the top address minus one sets l_irq in the next cycle. A left-port read (oe=1) of that address clears it.
- R8: While a port's inhibit input is 1, its write changes no memory word and sets no interrupt.
- R9: When both ports write the same address in the same cycle, the left port's data is stored.
- R10: A read that meets a write from the other port to the same address in the same cycle returns the word's previous content.
- R11: When a mailbox set and the matching clearing read occur in the same cycle, the interrupt ends up asserted.
- R12: Mailbox words keep the byte written to them and return it on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port enable |
| l_rnw | input | 1 | Left read (1) or write (0) |
| l_oe | input | 1 | Left output enable for reads |
| l_inhibit | input | 1 | Left write inhibit from the arbiter |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid, one-cycle pulse |
| l_irq | output | 1 | Interrupt to the left side, active high |
| r_en | input | 1 | Right port enable |
| r_rnw | input | 1 | Right read (1) or write (0) |
| r_oe | input | 1 | Right output enable for reads |
| r_inhibit | input | 1 | Right write inhibit from the arbiter |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid, one-cycle pulse |
| r_irq | output | 1 | Interrupt to the right side, active high |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8, a 16-word memory. With only 16 words, every address can be swept in each mode: plain writes and readback from the opposite side, disabled ports, reads with the output masked, inhibited writes, same-address write collisions and read-against-write collisions. Both mailbox addresses are reached inside those same sweeps. Expected data are arithmetic functions of the address, and a small shadow model applies the requirement rules for flags and collisions.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  typedef struct packed {
    logic en;
    logic rnw;
    logic oe;
    logic inhibit;
  } port_req_t;

  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
endpackage

// File: rtl/dpram_port_dec.sv
`timescale 1ns/1ps
module dpram_port_dec
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  port_req_t         req,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_go,
  output logic              rd_go,
  output logic              at_top,
  output logic              at_next
);
  localparam logic [ADDR_W-1:0] TOP_A  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;

  always_comb begin
    wr_go   = req.en && !req.rnw && !req.inhibit;
    rd_go   = req.en && req.rnw && req.oe;
    at_top  = (addr == TOP_A);
    at_next = (addr == NEXT_A);
  end
endmodule

// File: rtl/dpram_store.sv
`timescale 1ns/1ps
module dpram_store #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The right write goes first so that the left write overrides it on a
  // shared address.
  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  // Reads sample the word before this edge's writes land.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata  <= '0;
      l_rvalid <= 1'b0;
      r_rdata  <= '0;
      r_rvalid <= 1'b0;
    end else begin
      l_rvalid <= l_rd;
      r_rvalid <= r_rd;
      l_rdata  <= l_rd ? mem[l_addr] : '0;
      r_rdata  <= r_rd ? mem[r_addr] : '0;
    end
  end

  assert_l_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_rd));
  assert_r_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r_rvalid |-> $past(r_rd));
  assert_left_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && r_wr && (l_addr == r_addr)) |=> (mem[$past(l_addr)] == $past(l_wdata)));
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq
);
  // A set in the same cycle as a clear wins, so that a message is not lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq <= 1'b0;
    else if (set_i) irq <= 1'b1;
    else if (clr_i) irq <= 1'b0;
  end

  assert_rise_needs_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_i));
  assert_fall_needs_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_i && !set_i));
endmodule

// File: rtl/mbox_dpram.sv
`timescale 1ns/1ps
module mbox_dpram
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_rnw,
  input  logic              l_oe,
  input  logic              l_inhibit,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_irq,
  input  logic              r_en,
  input  logic              r_rnw,
  input  logic              r_oe,
  input  logic              r_inhibit,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_irq
);
  localparam int unsigned SIDES = 2;

  port_req_t         req    [SIDES];
  logic [ADDR_W-1:0] addr_s [SIDES];
  logic [SIDES-1:0]  wr_go, rd_go, at_top, at_next;

  always_comb begin
    req[SIDE_L]    = '{en: l_en, rnw: l_rnw, oe: l_oe, inhibit: l_inhibit};
    req[SIDE_R]    = '{en: r_en, rnw: r_rnw, oe: r_oe, inhibit: r_inhibit};
    addr_s[SIDE_L] = l_addr;
    addr_s[SIDE_R] = r_addr;
  end

  for (genvar g = 0; g < SIDES; g++) begin : g_dec
    dpram_port_dec #(.ADDR_W(ADDR_W)) u_dec (
      .req     (req[g]),
      .addr    (addr_s[g]),
      .wr_go   (wr_go[g]),
      .rd_go   (rd_go[g]),
      .at_top  (at_top[g]),
      .at_next (at_next[g])
    );
  end

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_wr     (wr_go[SIDE_L]),
    .l_rd     (rd_go[SIDE_L]),
    .l_addr   (l_addr),
    .l_wdata  (l_wdata),
    .r_wr     (wr_go[SIDE_R]),
    .r_rd     (rd_go[SIDE_R]),
    .r_addr   (r_addr),
    .r_wdata  (r_wdata),
    .l_rdata  (l_rdata),
    .l_rvalid (l_rvalid),
    .r_rdata  (r_rdata),
    .r_rvalid (r_rvalid)
  );

  // Left to right: the top word.
  dpram_mailbox u_mbox_to_r (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_go[SIDE_L] && at_top[SIDE_L]),
    .clr_i (rd_go[SIDE_R] && at_top[SIDE_R]),
    .irq   (r_irq)
  );

  // Right to left: the word below the top.
  dpram_mailbox u_mbox_to_l (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_go[SIDE_R] && at_next[SIDE_R]),
    .clr_i (rd_go[SIDE_L] && at_next[SIDE_L]),
    .irq   (l_irq)
  );

  assert_l_inhibit_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && !l_rnw && l_inhibit) |=> !$rose(r_irq));
  assert_r_inhibit_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && !r_rnw && r_inhibit) |=> !$rose(l_irq));
  assert_masked_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_rnw && !r_oe && !(l_en && l_rnw && l_oe)) |=> !$fell(r_irq));
  assert_l_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_irq) |-> $past(r_en && !r_rnw && !r_inhibit));
endmodule

// File: tb/mbox_dpram_tb.sv
`timescale 1ns/1ps
module mbox_dpram_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOPA = AW'(DEPTH - 1);
  localparam logic [AW-1:0] NXTA = AW'(DEPTH - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_rnw = 1, l_oe = 0, l_inh = 0;
  logic r_en = 0, r_rnw = 1, r_oe = 0, r_inh = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_irq, r_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] m [DEPTH];
  logic e_lirq = 0, e_rirq = 0;

  always #5 clk = ~clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_rnw(l_rnw), .l_oe(l_oe), .l_inhibit(l_inh),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_rvalid(l_rvalid), .l_irq(l_irq),
    .r_en(r_en), .r_rnw(r_rnw), .r_oe(r_oe), .r_inhibit(r_inh),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_rvalid(r_rvalid), .r_irq(r_irq)
  );

  function automatic logic [DW-1:0] pat_a(int a);
    return DW'((a * 29 + 3) & 255);
  endfunction
  function automatic logic [DW-1:0] pat_b(int a);
    return DW'(((a * 53 + 11) ^ 165) & 255);
  endfunction

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Vector layout: {l_rvalid, l_rdata, r_rvalid, r_rdata, l_irq, r_irq}
  task automatic step(string tag,
      logic le, logic lrnw, logic loe, logic linh, int la, logic [DW-1:0] lw,
      logic re, logic rrnw, logic roe, logic rinh, int ra, logic [DW-1:0] rw);
    logic lrd, lwr, rrd, rwr;
    logic [19:0] exp;
    l_en = le; l_rnw = lrnw; l_oe = loe; l_inh = linh; l_addr = AW'(la); l_wdata = lw;
    r_en = re; r_rnw = rrnw; r_oe = roe; r_inh = rinh; r_addr = AW'(ra); r_wdata = rw;
    lrd = le && lrnw && loe;  lwr = le && !lrnw && !linh;
    rrd = re && rrnw && roe;  rwr = re && !rrnw && !rinh;
    exp[19]    = lrd;
    exp[18:11] = lrd ? m[la] : '0;
    exp[10]    = rrd;
    exp[9:2]   = rrd ? m[ra] : '0;
    if (lwr && AW'(la) == TOPA)      e_rirq = 1'b1;
    else if (rrd && AW'(ra) == TOPA) e_rirq = 1'b0;
    if (rwr && AW'(ra) == NXTA)      e_lirq = 1'b1;
    else if (lrd && AW'(la) == NXTA) e_lirq = 1'b0;
    exp[1] = e_lirq;
    exp[0] = e_rirq;
    if (rwr) m[ra] = rw;
    if (lwr) m[la] = lw;
    @(negedge clk);
    check(tag, {l_rvalid, l_rdata, r_rvalid, r_rdata, l_irq, r_irq}, exp);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 1, 0, 0, 0, 8'h00, 0, 1, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", {l_rvalid, l_rdata, r_rvalid, r_rdata, l_irq, r_irq}, 20'h0);
    rst_n = 1'b1;
    idle("R1 idle after reset");

    // R2 / R6 / R12: left fills memory, right reads back (clears r_irq at top).
    for (int a = 0; a < DEPTH; a++) step("R2 R6 left write", 1,0,0,0,a,pat_a(a), 0,1,0,0,0,8'h0);
    for (int a = 0; a < DEPTH; a++) step("R3 R12 right read", 0,1,0,0,0,8'h0, 1,1,1,0,a,8'h0);
    idle("R3 valid drops");

    // R7: right fills, left reads back.
    for (int a = 0; a < DEPTH; a++) step("R2 R7 right write", 0,1,0,0,0,8'h0, 1,0,0,0,a,pat_b(a));
    for (int a = 0; a < DEPTH; a++) step("R7 R12 left read", 1,1,1,0,a,8'h0, 0,1,0,0,0,8'h0);

    // R4: disabled ports with write fields set.
    for (int a = 0; a < DEPTH; a++) step("R4 disabled", 0,0,1,0,a,8'h5A, 0,0,1,0,a,8'hC3);
    for (int a = 0; a < DEPTH; a++) step("R4 readback", 1,1,1,0,a,8'h0, 1,1,1,0,DEPTH-1-a,8'h0);

    // R5 / R6: masked reads neither return data nor clear.
    step("R6 set r_irq", 1,0,0,0,DEPTH-1,8'h77, 0,1,0,0,0,8'h0);
    step("R7 set l_irq", 0,1,0,0,0,8'h0, 1,0,0,0,DEPTH-2,8'h88);
    for (int a = 0; a < DEPTH; a++) step("R5 masked read", 1,1,0,0,a,8'h0, 1,1,0,0,a,8'h0);
    step("R6 writer-side read keeps", 1,1,1,0,DEPTH-1,8'h0, 0,1,0,0,0,8'h0);
    step("R7 writer-side read keeps", 0,1,0,0,0,8'h0, 1,1,1,0,DEPTH-2,8'h0);
    step("R6 R7 clear both", 1,1,1,0,DEPTH-2,8'h0, 1,1,1,0,DEPTH-1,8'h0);

    // R8: inhibited writes everywhere.
    for (int a = 0; a < DEPTH; a++) step("R8 inhibit", 1,0,0,1,a,8'hEE, 1,0,0,1,DEPTH-1-a,8'h11);
    for (int a = 0; a < DEPTH; a++) step("R8 readback", 1,1,1,0,a,8'h0, 0,1,0,0,0,8'h0);

    // R9: same-address write collision.
    for (int a = 0; a < DEPTH; a++) step("R9 collide", 1,0,0,0,a,pat_b(a+7), 1,0,0,0,a,pat_a(a+3));
    for (int a = 0; a < DEPTH; a++) step("R9 readback", 0,1,0,0,0,8'h0, 1,1,1,0,a,8'h0);

    // R10: read meets the other port's write.
    for (int a = 0; a < DEPTH; a++) step("R10 old data", 1,1,1,0,a,8'h0, 1,0,0,0,a,pat_a(a+9));
    for (int a = 0; a < DEPTH; a++) step("R10 new data", 1,1,1,0,a,8'h0, 0,1,0,0,0,8'h0);

    // R11: set and clear in one cycle.
    idle("R11 prep");
    step("R11 set", 1,0,0,0,DEPTH-1,8'h42, 0,1,0,0,0,8'h0);
    step("R11 set+clear", 1,0,0,0,DEPTH-1,8'h43, 1,1,1,0,DEPTH-1,8'h0);
    step("R11 clear alone", 0,1,0,0,0,8'h0, 1,1,1,0,DEPTH-1,8'h0);
    idle("R1 final idle");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule